// File: doc/BRIEF.md
# Immediate-Operand Add/Subtract Executor

This block runs a very small byte-coded 32-bit instruction stream. Instruction bytes come in one per clock over a valid/ready handshake. The block decodes two forms of instruction, and both add a 32-bit immediate to a destination or subtract it from one. The group form starts with a prefix byte and has an operand-select byte after it. That byte names the operation and one destination: either one of eight general registers, or a word in internal memory whose address is held in one of those registers. The short form always subtracts from register 0 and has no operand-select byte.

After the last immediate byte arrives, the block reads the destination, computes the result and writes it back. A one-cycle completion pulse then reports where the result went and what value was stored. Any encoding outside the supported subset raises a sticky illegal flag. From then on the block accepts no further bytes until a synchronous reset is applied.

Top module: `imm_alu_exec`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets all eight registers and every memory word to zero, clears illegal and doneValid, and leaves byteReady high so that a new opcode can be accepted.
- R2: The four immediate bytes arrive least-significant first, so the byte sequence 0a 0b 0c 0d gives the value 0x0d0c0b0a.
- R3: Opcode 0x81 followed by an operand byte with bits [7:6]=11 and bits [5:3]=000 adds the immediate to the register numbered by bits [2:0]. For example, 0xc3 adds to register 3.
- R4: With opcode 0x81, operand-byte bits [5:3]=101 subtract the immediate from the selected destination. For example, 0xeb subtracts from register 3.
- R5: With opcode 0x81, operand-byte bits [7:6]=00 and bits [2:0] not equal to 100 select as destination the memory word whose address is the low MEM_AW bits of the named register. The memory result is written back to that word, and the register is left unchanged.
- R6: Opcode 0x2d is followed directly by four immediate bytes, and the block subtracts that value from register 0.
- R7: Arithmetic is 32-bit two's complement and wraps silently. No flags are produced.
- R8: Each of the following raises illegal: an opcode other than 0x81 or 0x2d; operand-byte bits [5:3] other than 000 or 101; bits [7:6] equal to 01 or 10; bits [7:6]=00 with bits [2:0]=100. Once illegal is high, it stays high, byteReady stays low and no write-back occurs until reset.
- R9: Every completed instruction produces exactly one doneValid pulse, one cycle long. With it, doneIsMem reports the destination kind (0 for a register, 1 for memory), doneTarget reports the register index or memory word address, and doneValue reports the stored result.
- R10: A byte is consumed only in a cycle where byteValid and byteReady are both high. Idle gaps in the byte stream, at any position within an instruction, do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | An instruction byte is present |
| byteData | input | 8 | Instruction byte |
| byteReady | output | 1 | Block can take a byte this cycle |
| illegal | output | 1 | Sticky illegal-encoding flag; while it is high the block is halted |
| doneValid | output | 1 | One-cycle write-back pulse |
| doneIsMem | output | 1 | 1 when the destination was memory |
| doneTarget | output | MEM_AW | Register index or memory word address |
| doneValue | output | DATA_W | Value written back |

## Verification
The add and subtract paths are tried with register destinations, with memory destinations reached through an address register, and with the short form. Fixed cases pin down byte order and the group/short split. Random immediates and destinations cover all three forms, and the random runs also check that a memory write leaves the address register untouched. Operands chosen to cross zero and all-ones tell wraparound apart from saturation. Each illegal pattern (bad sub-operation, mod 01, mod 10, the escape r/m value, unknown opcode) is checked to halt the block without a write. Idle gaps are inserted at random positions, which shows that only handshaked bytes are consumed.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  localparam logic [7:0] OPC_GROUP = 8'h81;
  localparam logic [7:0] OPC_SUBACC = 8'h2d;
  localparam logic [1:0] MOD_DIRECT = 2'b11;
  localparam logic [1:0] MOD_INDIRECT = 2'b00;
  localparam logic [2:0] FN_ADD = 3'd0;
  localparam logic [2:0] FN_SUB = 3'd5;
  localparam logic [2:0] RM_ESCAPE = 3'd4;
  localparam int REG_AW = 3;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_IMM, ST_EXEC, ST_HALT
  } ctrlState_t;

  typedef struct packed {
    logic takeModrm;
    logic takeShort;
    logic shiftImm;
    logic exec;
  } dpStrobe_t;
endpackage

// File: rtl/imm_alu_ctrl.sv
module imm_alu_ctrl
  import imm_alu_pkg::*;
#(
  parameter int IMM_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       byteReady,
  output logic       illegal,
  output dpStrobe_t  strobe
);
  localparam int CNT_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] immCnt;
  logic accept, modrmLegal, lastImm;

  assign byteReady = (state != ST_EXEC) && (state != ST_HALT);
  assign illegal = (state == ST_HALT);
  assign accept = byteValid && byteReady;
  assign lastImm = (immCnt == CNT_W'(IMM_BYTES - 1));

  always_comb begin
    modrmLegal = ((byteData[7:6] == MOD_DIRECT) ||
                  ((byteData[7:6] == MOD_INDIRECT) && (byteData[2:0] != RM_ESCAPE))) &&
                 ((byteData[5:3] == FN_ADD) || (byteData[5:3] == FN_SUB));
  end

  always_comb begin
    stateNext = state;
    strobe = '0;
    unique case (state)
      ST_OPC: if (accept) begin
        if (byteData == OPC_GROUP) stateNext = ST_MODRM;
        else if (byteData == OPC_SUBACC) begin
          stateNext = ST_IMM;
          strobe.takeShort = 1'b1;
        end else stateNext = ST_HALT;
      end
      ST_MODRM: if (accept) begin
        if (modrmLegal) begin
          stateNext = ST_IMM;
          strobe.takeModrm = 1'b1;
        end else stateNext = ST_HALT;
      end
      ST_IMM: if (accept) begin
        strobe.shiftImm = 1'b1;
        if (lastImm) stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        strobe.exec = 1'b1;
        stateNext = ST_OPC;
      end
      default: stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPC;
      immCnt <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_IMM) immCnt <= '0;
      else if (accept) immCnt <= immCnt + 1'b1;
    end
  end

  // R8
  halt_ready_chk: assert property (@(posedge clk) disable iff (rst) illegal |-> !byteReady);
  // R8
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst) illegal |=> illegal);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPC && !byteValid) |=> (state == ST_OPC));
  // R9
  exec_once_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC) |=> (state == ST_OPC));
endmodule

// File: rtl/imm_alu_dp.sv
module imm_alu_dp
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        byteData,
  input  dpStrobe_t         strobe,
  output logic              doneValid,
  output logic              doneIsMem,
  output logic [MEM_AW-1:0] doneTarget,
  output logic [DATA_W-1:0] doneValue
);
  localparam int NREGS = 1 << REG_AW;
  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] regFile [NREGS];
  logic [DATA_W-1:0] dataMem [MEM_DEPTH];
  logic [DATA_W-1:0] immVal, baseVal, operand, result;
  logic [REG_AW-1:0] rmIdx;
  logic [MEM_AW-1:0] memAddr;
  logic isMem, useSub;

  always_comb begin
    baseVal = regFile[rmIdx];
    memAddr = baseVal[MEM_AW-1:0];
    operand = isMem ? dataMem[memAddr] : baseVal;
    result = useSub ? (operand - immVal) : (operand + immVal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regFile[i] <= '0;
      for (int j = 0; j < MEM_DEPTH; j++) dataMem[j] <= '0;
      immVal <= '0;
      rmIdx <= '0;
      isMem <= 1'b0;
      useSub <= 1'b0;
      doneValid <= 1'b0;
      doneIsMem <= 1'b0;
      doneTarget <= '0;
      doneValue <= '0;
    end else begin
      doneValid <= strobe.exec;
      if (strobe.takeShort) begin
        isMem <= 1'b0;
        useSub <= 1'b1;
        rmIdx <= '0;
      end
      if (strobe.takeModrm) begin
        isMem <= (byteData[7:6] == MOD_INDIRECT);
        useSub <= (byteData[5:3] == FN_SUB);
        rmIdx <= byteData[2:0];
      end
      if (strobe.shiftImm) immVal <= {byteData, immVal[DATA_W-1:8]};
      if (strobe.exec) begin
        if (isMem) dataMem[memAddr] <= result;
        else regFile[rmIdx] <= result;
        doneIsMem <= isMem;
        doneTarget <= isMem ? memAddr : MEM_AW'(rmIdx);
        doneValue <= result;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) doneValid |=> !doneValid);
  // R9
  reg_target_chk: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !doneIsMem) |-> (doneTarget < MEM_AW'(NREGS)));
  // R6
  short_dest_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.takeShort |=> (rmIdx == '0 && useSub && !isMem));
endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              byteReady,
  output logic              illegal,
  output logic              doneValid,
  output logic              doneIsMem,
  output logic [MEM_AW-1:0] doneTarget,
  output logic [DATA_W-1:0] doneValue
);
  localparam int IMM_BYTES = DATA_W / 8;

  dpStrobe_t strobe;

  imm_alu_ctrl #(.IMM_BYTES(IMM_BYTES)) ctrl_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .illegal(illegal), .strobe(strobe)
  );

  imm_alu_dp #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) dp_i (
    .clk(clk), .rst(rst), .byteData(byteData), .strobe(strobe),
    .doneValid(doneValid), .doneIsMem(doneIsMem), .doneTarget(doneTarget),
    .doneValue(doneValue)
  );
endmodule

// File: tb/imm_alu_exec_tb_top.sv
`timescale 1ns/1ps
module imm_alu_exec_tb_top;
  logic clk = 1'b0;
  logic rst, byteValid, byteReady, illegal, doneValid, doneIsMem;
  logic [7:0] byteData, doneTarget;
  logic [31:0] doneValue;
  logic [31:0] mReg [8];
  logic [31:0] mMem [256];
  int vec = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  imm_alu_exec dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .illegal(illegal), .doneValid(doneValid),
    .doneIsMem(doneIsMem), .doneTarget(doneTarget), .doneValue(doneValue)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] calc(input logic [31:0] a, input logic [31:0] b, input bit sub);
    return sub ? a - b : a + b;
  endfunction

  task automatic doReset();
    rst = 1'b1; byteValid = 1'b0; byteData = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    for (int i = 0; i < 256; i++) mMem[i] = '0;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input int gap);
    int t;
    byteValid = 1'b0;
    repeat (gap) @(negedge clk);
    byteValid = 1'b1; byteData = b;
    t = 0;
    while (!byteReady && t < 20) begin @(negedge clk); t++; end
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic sendImm(input logic [31:0] imm, input bit gaps);
    for (int k = 0; k < 4; k++) sendByte(imm[8*k +: 8], gaps ? int'($urandom_range(2)) : 0);
  endtask

  task automatic waitDone(input string req, input bit expMem, input logic [7:0] expTgt, input logic [31:0] expVal);
    int t = 0;
    while (!doneValid && t < 8) begin @(negedge clk); t++; end
    chk(req, "done seen", {31'd0, doneValid}, 32'd1);
    chk(req, "kind", {31'd0, doneIsMem}, {31'd0, expMem});
    chk(req, "target", {24'd0, doneTarget}, {24'd0, expTgt});
    chk(req, "value", doneValue, expVal);
    @(negedge clk);
    chk("R9", "pulse width", {31'd0, doneValid}, 32'd0);
  endtask

  task automatic runGrp(input string req, input bit mem, input bit sub, input logic [2:0] rm,
                        input logic [31:0] imm, input bit gaps);
    logic [7:0] addr;
    logic [31:0] r;
    sendByte(8'h81, gaps ? int'($urandom_range(2)) : 0);
    sendByte({mem ? 2'b00 : 2'b11, sub ? 3'd5 : 3'd0, rm}, gaps ? int'($urandom_range(2)) : 0);
    sendImm(imm, gaps);
    if (mem) begin
      addr = mReg[rm][7:0];
      r = calc(mMem[addr], imm, sub);
      mMem[addr] = r;
      waitDone(req, 1'b1, addr, r);
    end else begin
      r = calc(mReg[rm], imm, sub);
      mReg[rm] = r;
      waitDone(req, 1'b0, {5'd0, rm}, r);
    end
  endtask

  task automatic runShort(input string req, input logic [31:0] imm, input bit gaps);
    sendByte(8'h2d, gaps ? int'($urandom_range(2)) : 0);
    sendImm(imm, gaps);
    mReg[0] = mReg[0] - imm;
    waitDone(req, 1'b0, 8'd0, mReg[0]);
  endtask

  task automatic setReg(input logic [2:0] rm, input logic [31:0] val);
    runGrp("R4", 1'b0, 1'b1, rm, mReg[rm], 1'b0);
    runGrp("R3", 1'b0, 1'b0, rm, val, 1'b0);
  endtask

  task automatic expectHalt(input string req);
    @(negedge clk);
    chk(req, "illegal", {31'd0, illegal}, 32'd1);
    chk(req, "ready low", {31'd0, byteReady}, 32'd0);
    byteValid = 1'b1; byteData = 8'h81;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (doneValid || byteReady || !illegal) chk(req, "halted state", 32'd1, 32'd0);
    end
    byteValid = 1'b0;
    doReset();
    chk("R1", "illegal cleared", {31'd0, illegal}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] rm;
    int kind;
    void'($urandom(32'd20171012));
    doReset();
    // R1 reset state
    chk("R1", "ready", {31'd0, byteReady}, 32'd1);
    chk("R1", "illegal", {31'd0, illegal}, 32'd0);
    chk("R1", "doneValid", {31'd0, doneValid}, 32'd0);
    runGrp("R1", 1'b0, 1'b0, 3'd5, 32'd0, 1'b0);
    // R2/R3: register add with byte order
    runGrp("R3", 1'b0, 1'b0, 3'd3, 32'd1, 1'b0);
    runGrp("R2", 1'b0, 1'b0, 3'd3, 32'h0d0c0b0a, 1'b0);
    chk("R2", "reg3 sum", mReg[3], 32'h0d0c0b0b);
    // R4: register subtract
    setReg(3'd3, 32'd10);
    runGrp("R4", 1'b0, 1'b1, 3'd3, 32'd1, 1'b0);
    // R5: memory through register 3 = 0x60
    setReg(3'd3, 32'h60);
    runGrp("R5", 1'b1, 1'b0, 3'd3, 32'd10, 1'b0);
    runGrp("R5", 1'b1, 1'b1, 3'd3, 32'd1, 1'b0);
    chk("R5", "mem value", mMem[8'h60], 32'd9);
    runGrp("R5", 1'b0, 1'b0, 3'd3, 32'd0, 1'b0);
    // R6: short form
    runGrp("R6", 1'b0, 1'b0, 3'd0, 32'h0d0c0baa, 1'b0);
    runShort("R6", 32'h0d0c0b0a, 1'b0);
    chk("R6", "reg0", mReg[0], 32'h000000a0);
    // R7: wraparound
    runGrp("R7", 1'b0, 1'b0, 3'd1, 32'hffffffff, 1'b0);
    runGrp("R7", 1'b0, 1'b0, 3'd1, 32'd2, 1'b0);
    runGrp("R7", 1'b0, 1'b1, 3'd2, 32'd1, 1'b0);
    // R10: random gaps
    for (int n = 0; n < 20; n++) runGrp("R10", 1'b0, n[0], 3'($urandom_range(7)), $urandom, 1'b1);
    // random mix
    for (int n = 0; n < 300; n++) begin
      kind = int'($urandom_range(2));
      rm = 3'($urandom_range(7));
      if (kind == 0) runGrp("R3", 1'b0, 1'($urandom_range(1)), rm, $urandom, 1'($urandom_range(1)));
      else if (kind == 1) begin
        if (rm == 3'd4) rm = 3'd6;
        if (mReg[rm] > 32'd255) setReg(rm, 32'($urandom_range(255)));
        runGrp("R5", 1'b1, 1'($urandom_range(1)), rm, $urandom, 1'($urandom_range(1)));
        runGrp("R5", 1'b0, 1'b0, rm, 32'd0, 1'b0);
      end else runShort("R6", $urandom, 1'($urandom_range(1)));
    end
    // R8: illegal encodings
    sendByte(8'h81, 0); sendByte(8'hcb, 0); expectHalt("R8");
    sendByte(8'h81, 0); sendByte(8'h43, 0); expectHalt("R8");
    sendByte(8'h81, 0); sendByte(8'h83, 0); expectHalt("R8");
    sendByte(8'h81, 0); sendByte(8'h04, 0); expectHalt("R8");
    sendByte(8'h05, 0); expectHalt("R8");
    runGrp("R1", 1'b0, 1'b0, 3'd3, 32'd7, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule